// File: doc/BRIEF.md
# Tagged Half-Word Store Stage

This block executes store instructions for a small 16-bit coprocessor. Each cycle it can accept one decoded store instruction. With it come the values of the two registers the instruction names and the current program counter. One cycle later it drives a single write into a 32-bit, word-addressed memory, with a separate write enable for each half-word. The instruction fetch, the register file and the memory array sit outside the block.

The block has two addressing styles. A direct store adds an 11-bit immediate to an address register. A streaming store takes its address from an internally held pointer. A separate preset operation loads that pointer, and the pointer then moves forward as stores complete. In streaming half-word mode the writes alternate between the low and high half of a word, and the pointer only moves on once both halves are written. Stored data can carry a 2-bit tag, and full-word stores also record the PC of the storing instruction.

Top module: `tagged_store_stage`

## Requirements
- R1: A memory write (`mem_we` high for one cycle, one clock after the instruction is presented) happens only when `in_valid` is high, the opcode field insn[31:28] equals 6, the sub-operation field insn[27:25] is 4 (direct) or 1 (streaming), and the format field insn[8:7] is not 2. In every other case `mem_we` is low and `mem_be` is 0 in the following cycle.
- R2: A direct store writes to the word address (value of the register named by insn[3:2]) + insn[20:10], taken modulo 2048. Its data comes from the register named by insn[1:0].
- R3: Format 0 writes the full word {PC[10:0], 3'b000, tag[1:0], data[15:0]}, where the tag is insn[5:4], with `mem_be` = 2'b11.
- R4: Format 1 writes the half-word {tag[1:0], data[13:0]}.
- R5: Format 3 writes data[15:0] unchanged into one half-word. Every half-word store places its half-word value in both halves of `mem_wdata`.
- R6: For a direct half-word store, insn[6] = 0 selects bits 15:0 (`mem_be` = 2'b01) and insn[6] = 1 selects bits 31:16 (`mem_be` = 2'b10).
- R7: Sub-operation 3 loads the streaming pointer from insn[20:10] and resets the half selector to low. It writes nothing.
- R8: After each pointer load, streaming half-word stores go low, high, low, high and so on. The pointer increases by one after each high-half store.
- R9: A streaming full-word store increases the pointer by one after every write and leaves the half selector unchanged.
- R10: A streaming store writes to the word address (value of the register named by insn[1:0]) + pointer, taken modulo 2048. Its data comes from the register named by insn[3:2].
- R11: A store with format 2 writes nothing and leaves both the pointer and the half selector unchanged.
- R12: After reset `mem_we` is low, `mem_be` is 0, the pointer is 0 and the half selector is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction on `insn` is valid this cycle |
| insn | input | 32 | Store instruction word |
| fld_a_val | input | 16 | Value of the register named by insn[1:0] |
| fld_b_val | input | 16 | Value of the register named by insn[3:2] |
| pc | input | 11 | Word address of the instruction |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 11 | Word address of the write |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 2 | Half-word enables: bit 0 = bits 15:0, bit 1 = bits 31:16 |

## Verification
The bench builds the block with its default widths: 11-bit addresses, 16-bit data and a 2-bit tag. These widths make the 2048-word wrap of both the direct sum and the streaming pointer reachable from a preset near the top of the space. They also make the full packing of PC, padding and tag into one 32-bit word directly observable. Directed sequences cover a pointer preset in the middle of a half-word pair, reserved-format stores between a pair, and full-word stores mixed into a half-word stream. A long biased random run then exercises the interleavings of these cases.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int INSN_W     = 32;
  localparam int OPC_LO     = 28;
  localparam int SUB_LO     = 25;
  localparam int OFS_LO     = 10;
  localparam int FMT_LO     = 7;
  localparam int HALF_BIT   = 6;
  localparam int TAG_LO     = 4;

  localparam logic [3:0] OPC_STORE  = 4'd6;
  localparam logic [2:0] SUB_STREAM = 3'd1;
  localparam logic [2:0] SUB_PRESET = 3'd3;
  localparam logic [2:0] SUB_DIRECT = 3'd4;

  typedef enum logic [1:0] {
    FMT_FULL = 2'd0,
    FMT_TAG  = 2'd1,
    FMT_RSVD = 2'd2,
    FMT_RAW  = 2'd3
  } fmt_e;
endpackage

// File: rtl/tss_decode.sv
module tss_decode
  import tss_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int TAG_W  = 2
) (
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  output logic              wr_go,
  output logic              preset_go,
  output logic              rsvd_hit,
  output logic              stream_sel,
  output logic              full_sel,
  output logic              raw_sel,
  output logic              half_hi_bit,
  output logic [TAG_W-1:0]  tag,
  output logic [ADDR_W-1:0] ofs_imm
);
  logic       is_store;
  logic [2:0] sub;
  fmt_e       fmt;
  logic       direct_op, stream_op;

  assign is_store    = in_valid && (insn[OPC_LO +: 4] == OPC_STORE);
  assign sub         = insn[SUB_LO +: 3];
  assign fmt         = fmt_e'(insn[FMT_LO +: 2]);
  assign direct_op   = is_store && (sub == SUB_DIRECT);
  assign stream_op   = is_store && (sub == SUB_STREAM);
  assign rsvd_hit    = (direct_op || stream_op) && (fmt == FMT_RSVD);
  assign wr_go       = (direct_op || stream_op) && (fmt != FMT_RSVD);
  assign preset_go   = is_store && (sub == SUB_PRESET);
  assign stream_sel  = stream_op;
  assign full_sel    = (fmt == FMT_FULL);
  assign raw_sel     = (fmt == FMT_RAW);
  assign half_hi_bit = insn[HALF_BIT];
  assign tag         = insn[TAG_LO +: TAG_W];
  assign ofs_imm     = insn[OFS_LO +: ADDR_W];
endmodule

// File: rtl/tss_auto_ptr.sv
module tss_auto_ptr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset_go,
  input  logic [ADDR_W-1:0] ofs_imm,
  input  logic              step_full,
  input  logic              step_half,
  output logic [ADDR_W-1:0] cur_ofs,
  output logic              hi_next
);
  logic bump_evt;
  logic flip_evt;

  assign bump_evt = !preset_go && (step_full || (step_half && hi_next));
  assign flip_evt = !preset_go && step_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ofs <= '0;
      hi_next <= 1'b0;
    end else if (preset_go) begin
      cur_ofs <= ofs_imm;
      hi_next <= 1'b0;
    end else begin
      if (bump_evt) cur_ofs <= cur_ofs + ADDR_W'(1);
      if (flip_evt) hi_next <= ~hi_next;
    end
  end

  p_preset_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_go |=> (cur_ofs == $past(ofs_imm)) && !hi_next);

  p_low_then_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_half && !preset_go && !hi_next) |=> hi_next && $stable(cur_ofs));

  p_high_advances_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_half && !preset_go && hi_next) |=>
      !hi_next && (cur_ofs == ADDR_W'($past(cur_ofs) + ADDR_W'(1))));

  p_full_advances_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_full && !preset_go) |=>
      $stable(hi_next) && (cur_ofs == ADDR_W'($past(cur_ofs) + ADDR_W'(1))));

  p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_go && !step_full && !step_half) |=> $stable(cur_ofs) && $stable(hi_next));
endmodule

// File: rtl/tss_pack.sv
module tss_pack #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 2
) (
  input  logic                full_sel,
  input  logic                raw_sel,
  input  logic [TAG_W-1:0]    tag,
  input  logic [DATA_W-1:0]   data,
  input  logic [ADDR_W-1:0]   pc,
  output logic [2*DATA_W-1:0] word
);
  localparam int WORD_W = 2 * DATA_W;
  localparam int PAD_W  = WORD_W - ADDR_W - TAG_W - DATA_W;

  function automatic logic [DATA_W-1:0] half_value(input logic raw,
                                                   input logic [TAG_W-1:0] t,
                                                   input logic [DATA_W-1:0] d);
    if (raw) return d;
    return {t, d[DATA_W-TAG_W-1:0]};
  endfunction

  logic [WORD_W-1:0] full_w;
  logic [DATA_W-1:0] half_w;

  generate
    if (PAD_W > 0) begin : g_padded
      assign full_w = {pc, {PAD_W{1'b0}}, tag, data};
    end else begin : g_tight
      assign full_w = WORD_W'({pc, tag, data});
    end
  endgenerate

  assign half_w = half_value(raw_sel, tag, data);
  assign word   = full_sel ? full_w : {2{half_w}};
endmodule

// File: rtl/tagged_store_stage.sv
module tagged_store_stage
  import tss_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [31:0]         insn,
  input  logic [DATA_W-1:0]   fld_a_val,
  input  logic [DATA_W-1:0]   fld_b_val,
  input  logic [ADDR_W-1:0]   pc,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*DATA_W-1:0] mem_wdata,
  output logic [1:0]          mem_be
);
  localparam int WORD_W = 2 * DATA_W;

  logic              wr_go, preset_go, rsvd_hit, stream_sel, full_sel, raw_sel, half_hi_bit;
  logic [TAG_W-1:0]  tag;
  logic [ADDR_W-1:0] ofs_imm, cur_ofs, base, ofs_use, addr_nx;
  logic              hi_next, hi_sel, step_full, step_half;
  logic [DATA_W-1:0] data_sel;
  logic [WORD_W-1:0] word_nx;
  logic [1:0]        be_nx;

  tss_decode #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dec (
    .in_valid(in_valid), .insn(insn), .wr_go(wr_go), .preset_go(preset_go),
    .rsvd_hit(rsvd_hit), .stream_sel(stream_sel), .full_sel(full_sel),
    .raw_sel(raw_sel), .half_hi_bit(half_hi_bit), .tag(tag), .ofs_imm(ofs_imm)
  );

  assign step_full = wr_go && stream_sel && full_sel;
  assign step_half = wr_go && stream_sel && !full_sel;

  tss_auto_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .preset_go(preset_go), .ofs_imm(ofs_imm),
    .step_full(step_full), .step_half(step_half), .cur_ofs(cur_ofs), .hi_next(hi_next)
  );

  assign data_sel = stream_sel ? fld_b_val : fld_a_val;
  assign base     = stream_sel ? fld_a_val[ADDR_W-1:0] : fld_b_val[ADDR_W-1:0];
  assign ofs_use  = stream_sel ? cur_ofs : ofs_imm;
  assign addr_nx  = base + ofs_use;
  assign hi_sel   = stream_sel ? hi_next : half_hi_bit;
  assign be_nx    = full_sel ? 2'b11 : (hi_sel ? 2'b10 : 2'b01);

  tss_pack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_pack (
    .full_sel(full_sel), .raw_sel(raw_sel), .tag(tag), .data(data_sel),
    .pc(pc), .word(word_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_be    <= 2'b00;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= wr_go;
      mem_be <= wr_go ? be_nx : 2'b00;
      if (wr_go) begin
        mem_addr  <= addr_nx;
        mem_wdata <= word_nx;
      end
    end
  end

  p_strobe_enables_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we ? (mem_be != 2'b00) : (mem_be == 2'b00));

  p_idle_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !mem_we);

  p_half_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be != 2'b11) |-> ($countones(mem_be) == 1));

  p_preset_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_go |=> !mem_we);

  p_reserved_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_hit |=> !mem_we);
endmodule

// File: tb/sim_tagged_store_stage.sv
`timescale 1ns/1ps
module sim_tagged_store_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [15:0] fa = '0, fb = '0;
  logic [10:0] pc = '0;
  logic        mem_we;
  logic [10:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [1:0]  mem_be;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_ptr = 0;
  bit m_hi  = 0;

  always #4 clk = ~clk;

  tagged_store_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .fld_a_val(fa), .fld_b_val(fb), .pc(pc), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be)
  );

  function automatic logic [31:0] enc(int sub, int fmt, int up, int tg, int ofs);
    return {4'd6, 3'(sub), 4'd0, 11'(ofs), 1'b0, 2'(fmt), 1'(up), 2'(tg), 4'd0};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // Drive at a falling edge, predict, compare at the next falling edge.
  task automatic step(bit v, logic [31:0] ins, int a, int b, int p, string req);
    int op, sub, fmt, up, tg, ofs, dat, adr, h;
    bit hi, e_we;
    logic [31:0] e_wd;
    logic [1:0]  e_be;
    in_valid = v; insn = ins; fa = 16'(a); fb = 16'(b); pc = 11'(p);
    op = int'(ins[31:28]); sub = int'(ins[27:25]); fmt = int'(ins[8:7]);
    up = int'(ins[6]); tg = int'(ins[5:4]); ofs = int'(ins[20:10]);
    e_we = 0; e_be = 0; e_wd = 0; adr = 0;
    if (v && op == 6) begin
      if (sub == 3) begin
        m_ptr = ofs; m_hi = 0;
      end else if ((sub == 4 || sub == 1) && fmt != 2) begin
        e_we = 1;
        if (sub == 4) begin
          dat = b & 16'hFFFF; adr = ((a & 0) + (b & 16'hFFFF) + ofs) % 2048; dat = a & 16'hFFFF; hi = up[0];
        end else begin
          dat = b & 16'hFFFF; adr = ((a & 16'hFFFF) + m_ptr) % 2048; hi = m_hi;
          if (fmt == 0) m_ptr = (m_ptr + 1) % 2048;
          else begin
            if (m_hi) m_ptr = (m_ptr + 1) % 2048;
            m_hi = !m_hi;
          end
        end
        if (fmt == 0) begin
          e_wd = (32'(p & 2047) << 21) | (32'(tg) << 16) | 32'(dat);
          e_be = 2'b11;
        end else begin
          h = (fmt == 1) ? ((tg << 14) | (dat & 16'h3FFF)) : dat;
          e_wd = (32'(h) << 16) | 32'(h);
          e_be = hi ? 2'b10 : 2'b01;
        end
      end
    end
    @(negedge clk);
    check(mem_we == e_we, req, "mem_we", 32'(mem_we), 32'(e_we));
    check(mem_be == e_be, req, "mem_be", 32'(mem_be), 32'(e_be));
    if (e_we) begin
      check(mem_addr == 11'(adr), req, "mem_addr", 32'(mem_addr), 32'(adr));
      check(mem_wdata == e_wd, req, "mem_wdata", mem_wdata, e_wd);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state visible at the ports
    check(mem_we == 1'b0, "R12", "mem_we after reset", 32'(mem_we), 0);
    check(mem_be == 2'b00, "R12", "mem_be after reset", 32'(mem_be), 0);
    // R12/R10: first streaming half store after reset goes low at base+0
    step(1, enc(1, 3, 0, 0, 0), 100, 16'h1234, 0, "R12");
    // R3/R2: direct full word with PC and tag
    step(1, enc(4, 0, 0, 2, 5), 16'hBEEF, 20, 11'h7FF, "R3");
    // R4/R6: tagged half into the high half
    step(1, enc(4, 1, 1, 3, 9), 16'h0001, 7, 3, "R4");
    step(1, enc(4, 1, 0, 1, 9), 16'hFFFF, 7, 3, "R6");
    // R5: raw half into the low half
    step(1, enc(4, 3, 0, 2, 1), 16'hA5A5, 40, 0, "R5");
    // R2: address wraps
    step(1, enc(4, 3, 1, 0, 20), 16'h0F0F, 2040, 0, "R2");
    // R7: preset near the top of the space, writes nothing
    step(1, enc(3, 0, 0, 0, 2045), 0, 0, 0, "R7");
    // R8: low, high, then next word low
    step(1, enc(1, 3, 0, 0, 0), 0, 16'h1111, 0, "R8");
    step(1, enc(1, 1, 0, 2, 0), 0, 16'h2222, 0, "R8");
    step(1, enc(1, 3, 0, 0, 0), 0, 16'h3333, 0, "R8");
    // R11: reserved format mid-pair, then pair continues in the high half
    step(1, enc(1, 2, 0, 0, 0), 0, 16'h4444, 0, "R11");
    step(1, enc(4, 2, 1, 0, 3), 16'h5555, 9, 0, "R11");
    step(1, enc(1, 3, 0, 0, 0), 0, 16'h6666, 0, "R11");
    // R9: full word at 2047 wraps pointer, half selector untouched
    step(1, enc(1, 0, 0, 1, 0), 0, 16'h7777, 11'h123, "R9");
    step(1, enc(1, 3, 0, 0, 0), 0, 16'h8888, 0, "R9");
    // R7: preset mid-pair resets to low half
    step(1, enc(3, 0, 0, 0, 10), 0, 0, 0, "R7");
    step(1, enc(1, 3, 0, 0, 0), 5, 16'h9999, 0, "R7");
    // R10: streaming base register plus pointer
    step(1, enc(1, 1, 0, 3, 0), 2047, 16'hABCD, 0, "R10");
    // R1: invalid, wrong opcode, other sub-operations
    step(0, enc(4, 3, 0, 0, 1), 1, 1, 0, "R1");
    step(1, enc(4, 3, 0, 0, 1) ^ 32'h1000_0000, 1, 1, 0, "R1");
    step(1, enc(0, 3, 0, 0, 1), 1, 1, 0, "R1");
    step(1, enc(6, 0, 0, 0, 1), 1, 1, 0, "R1");
    // biased random stream against the reference model
    for (int i = 0; i < 3000; i++) begin
      int r, sub;
      logic [31:0] w;
      r = int'($urandom % 10);
      sub = (r < 4) ? 1 : (r < 7) ? 4 : (r < 8) ? 3 : int'($urandom % 8);
      w = enc(sub, int'($urandom % 4), int'($urandom % 2), int'($urandom % 4),
              int'($urandom % 2048));
      w[3:0] = 4'($urandom);
      if ($urandom % 20 == 0) w[31:28] = 4'($urandom);
      step(($urandom % 8) != 0, w, int'($urandom % 65536), int'($urandom % 65536),
           int'($urandom % 2048), "R10");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule